// File: doc/BRIEF.md
# Recursive Pyramid Integer Multiplier

This block multiplies two unsigned operands of width `W` and returns the full `2W`-bit product. The product is built by peeling a narrow slice off the least-significant end of both operands, one level at a time. At each level the product of the remaining upper parts comes from the level above. The level then adds two AND-gated cross terms (each slice bit selects a shifted copy of the other operand's upper part) and a small slice-by-slice corner product, all at their weights. The top of the pyramid is a direct product of the last one or two bits.

The parameter `VARIANT` picks the slice width. With 0 (basic) each level peels one bit, so there are `W` levels. With 1 (modified) each level peels two bits and the top is a 2x2 product, which halves the level count. When the width is odd, the modified variant ends with a single-bit top instead. The arithmetic core is purely combinational. The parameter `OUT_REG` either adds one output register stage with a delayed valid flag, or passes the core product and valid straight through.

Top module: `pyramid_mul`

## Requirements
- R1: With VARIANT=0, `product` equals the unsigned product of `op_a` and `op_b` for every input pair.
- R2: With VARIANT=1 and an even W, `product` equals the unsigned product for every input pair.
- R3: With VARIANT=1 and an odd W, where the pyramid ends in a one-bit top, `product` equals the unsigned product for every input pair.
- R4: If either operand is zero, `product` is zero.
- R5: If one operand is 1, `product` equals the other operand, zero-extended.
- R6: All-ones times all-ones gives W-1 ones, then a zero, then W-1 zeros, then a one, MSB first. For W=8 this is 0xFE01.
- R7: With OUT_REG=1, the product and `out_valid` appear one clock after a cycle with `in_valid` high. A cycle with `in_valid` low leaves `product` unchanged and drives `out_valid` low on the next edge. After reset, `out_valid` and `product` are 0.
- R8: With OUT_REG=0, `product` and `out_valid` follow the inputs in the same cycle, and `out_valid` equals `in_valid`.
- R9: No level's weighted sum needs more than 2W bits.
- R10: The product is exact at W=64 for zero, one, all-ones and arbitrary operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | Product is valid |
| product | output | 2W | Unsigned product |

## Verification
The assertions check on every evaluation that no level's weighted sum spills past 2W bits, that a zero operand gives a zero core product, and that all-ones squared gives its closed-form value. On every clock they also check that the registered stage captures the core product and flags valid one cycle after an accepted operand pair, and holds otherwise. Exactness of the product for all operand pairs can only be shown by the bench's sweeps. These cover the 8-bit basic and modified variants and the 7-bit odd-width pyramid exhaustively, and a 64-bit instance on corners and random pairs.

// File: rtl/pyr_pkg.sv
package pyr_pkg;
  localparam int VAR_BASIC = 0;
  localparam int VAR_MOD   = 1;

  // slice width peeled per level
  function automatic int step_w(input int variant);
    return (variant == VAR_MOD) ? 2 : 1;
  endfunction

  // 2x2 corner product from two gated rows; 1-bit slices are zero-extended
  function automatic logic [3:0] mul_2x2(input logic [1:0] x, input logic [1:0] y);
    logic [3:0] row0, row1;
    row0 = {2'b00, x} & {4{y[0]}};
    row1 = {1'b0, x, 1'b0} & {4{y[1]}};
    return row0 + row1;
  endfunction
endpackage

// File: rtl/pyr_base.sv
module pyr_base #(
  parameter int BW = 2,
  parameter int PW = 16
) (
  input  logic [BW-1:0] a_top,
  input  logic [BW-1:0] b_top,
  output logic [PW-1:0] prod
);
  logic [3:0] tiny;

  assign tiny = pyr_pkg::mul_2x2(2'(a_top), 2'(b_top));
  assign prod = PW'(tiny);
endmodule

// File: rtl/pyr_level.sv
module pyr_level #(
  parameter int M  = 8,   // width of this level's operand parts
  parameter int S  = 2,   // peeled slice width
  parameter int PW = 16
) (
  input  logic [M-1:0]  a_up,
  input  logic [M-1:0]  b_up,
  input  logic [PW-1:0] sub_prod,   // product of a_up[M-1:S] and b_up[M-1:S]
  output logic [PW-1:0] prod
);
  localparam int EW = PW + 4;

  logic [S-1:0]  a_lo, b_lo;
  logic [EW-1:0] a_hi, b_hi;
  logic [EW-1:0] cross_sum;
  logic [EW-1:0] total;
  logic [3:0]    corner;

  assign a_lo   = a_up[S-1:0];
  assign b_lo   = b_up[S-1:0];
  assign a_hi   = EW'(a_up[M-1:S]);
  assign b_hi   = EW'(b_up[M-1:S]);
  assign corner = pyr_pkg::mul_2x2(2'(a_lo), 2'(b_lo));

  // AND-gated cross terms: each slice bit picks a shifted copy of the other high part
  always_comb begin
    cross_sum = '0;
    for (int j = 0; j < S; j++) begin
      cross_sum = cross_sum + ((b_hi << j) & {EW{a_lo[j]}});
      cross_sum = cross_sum + ((a_hi << j) & {EW{b_lo[j]}});
    end
  end

  assign total = (EW'(sub_prod) << (2 * S)) + (cross_sum << S) + EW'(corner);
  assign prod  = total[PW-1:0];

  always_comb begin
    if (!$isunknown(total))
      assert_no_overflow_R9: assert (total[EW-1:PW] == '0)
        else $error("level sum exceeds product width");
  end
endmodule

// File: rtl/pyr_outstage.sv
module pyr_outstage #(
  parameter int PW = 16,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [PW-1:0] p_in,
  output logic          v_out,
  output logic [PW-1:0] p_out
);
  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_out <= 1'b0;
          p_out <= '0;
        end else begin
          v_out <= v_in;
          if (v_in) p_out <= p_in;
        end
      end

      assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out) else $error("valid not delayed by one cycle");
      assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> !v_out) else $error("valid raised without input");
      assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> (p_out == $past(p_in))) else $error("product not captured");
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> $stable(p_out)) else $error("product changed while idle");
    end else begin : g_pass
      assign v_out = v_in;
      assign p_out = p_in;
    end
  endgenerate
endmodule

// File: rtl/pyramid_mul.sv
module pyramid_mul #(
  parameter int W       = 16,
  parameter int VARIANT = 1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int PW     = 2 * W;
  localparam int STEP   = pyr_pkg::step_w(VARIANT);
  localparam int NLVL   = (W + STEP - 1) / STEP;
  localparam int BASE_K = STEP * (NLVL - 1);
  localparam int BASE_W = W - BASE_K;

  logic [PW-1:0] lvl_prod [NLVL];
  logic [PW-1:0] core_prod;

  pyr_base #(.BW(BASE_W), .PW(PW)) u_base (
    .a_top (op_a[W-1:BASE_K]),
    .b_top (op_b[W-1:BASE_K]),
    .prod  (lvl_prod[NLVL-1])
  );

  generate
    for (genvar i = 0; i < NLVL - 1; i++) begin : g_lvl
      localparam int K = STEP * i;
      pyr_level #(.M(W - K), .S(STEP), .PW(PW)) u_level (
        .a_up     (op_a[W-1:K]),
        .b_up     (op_b[W-1:K]),
        .sub_prod (lvl_prod[i+1]),
        .prod     (lvl_prod[i])
      );
    end
  endgenerate

  assign core_prod = lvl_prod[0];

  always_comb begin
    if (!$isunknown({op_a, op_b, core_prod})) begin
      if (op_a == '0 || op_b == '0)
        assert_zero_operand_R4: assert (core_prod == '0)
          else $error("zero operand gave nonzero product");
      if (&op_a && &op_b)
        assert_max_square_R6: assert (core_prod ==
          {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1})
          else $error("all-ones square wrong");
    end
  end

  pyr_outstage #(.PW(PW), .EN(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (in_valid),
    .p_in  (core_prod),
    .v_out (out_valid),
    .p_out (product)
  );
endmodule

// File: tb/test_pyramid_mul.sv
`timescale 1ns/1ps
module test_pyramid_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // 8-bit registered instances share inputs
  logic        v8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        ov_basic, ov_mod;
  logic [15:0] p_basic, p_mod;
  // 7-bit combinational modified instance
  logic        v7 = 1'b0;
  logic [6:0]  a7 = '0, b7 = '0;
  logic        ov7;
  logic [13:0] p7;
  // 64-bit registered modified instance
  logic        v64 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        ov64;
  logic [127:0] p64;

  pyramid_mul #(.W(8), .VARIANT(0), .OUT_REG(1'b1)) i_pyramid_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .op_a(a8), .op_b(b8),
    .out_valid(ov_basic), .product(p_basic));
  pyramid_mul #(.W(8), .VARIANT(1), .OUT_REG(1'b1)) i_pyramid_mul_mod8 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .op_a(a8), .op_b(b8),
    .out_valid(ov_mod), .product(p_mod));
  pyramid_mul #(.W(7), .VARIANT(1), .OUT_REG(1'b0)) i_pyramid_mul_mod7 (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .op_a(a7), .op_b(b7),
    .out_valid(ov7), .product(p7));
  pyramid_mul #(.W(64), .VARIANT(1), .OUT_REG(1'b1)) i_pyramid_mul_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(v64), .op_a(a64), .op_b(b64),
    .out_valid(ov64), .product(p64));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag8(input logic [7:0] x, input logic [7:0] y, input string dflt);
    if (x == 0 || y == 0) return "R4";
    if (x == 1 || y == 1) return "R5";
    if (&x && &y) return "R6";
    return dflt;
  endfunction

  task automatic wide_vec(input logic [63:0] x, input logic [63:0] y, input string tag);
    @(negedge clk);
    a64 = x; b64 = y; v64 = 1'b1;
    @(negedge clk);
    v64 = 1'b0;
    chk({tag, " valid"}, 128'(ov64), 128'(1));
    chk(tag, p64, {64'b0, x} * {64'b0, y});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_prev;
    logic [7:0]  pa, pb;
    bit have_prev;
    have_prev = 1'b0;
    exp_prev = '0; pa = '0; pb = '0;

    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 reset valid", 128'(ov_basic), 128'(0));
    chk("R7 reset product", 128'(p_mod), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive 8-bit sweep (R1, R2) with 7-bit combinational sweep (R3, R8)
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      if (have_prev) begin
        chk("R7 valid", 128'(ov_basic), 128'(1));
        chk(tag8(pa, pb, "R1"), 128'(p_basic), 128'(exp_prev));
        chk(tag8(pa, pb, "R2"), 128'(p_mod), 128'(exp_prev));
      end
      a8 = v[15:8]; b8 = v[7:0]; v8 = 1'b1;
      pa = a8; pb = b8;
      exp_prev = {8'b0, a8} * {8'b0, b8};
      have_prev = 1'b1;
      if (v < 16384) begin
        a7 = v[13:7]; b7 = v[6:0]; v7 = v[0];
        #1;
        chk("R3", 128'(p7), 128'({7'b0, a7} * {7'b0, b7}));
        chk("R8 valid follows", 128'(ov7), 128'(v7));
      end
    end
    @(negedge clk);
    chk("R7 last", 128'(p_basic), 128'(exp_prev));
    // R7: idle cycle holds the product and drops valid
    v8 = 1'b0; a8 = 8'h03; b8 = 8'h05;
    @(negedge clk);
    chk("R7 idle valid", 128'(ov_basic), 128'(0));
    chk("R7 hold", 128'(p_basic), 128'(exp_prev));
    chk("R7 hold mod", 128'(p_mod), 128'(exp_prev));
    v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    chk("R7 resume", 128'(p_mod), 128'(15));

    // R10: 64-bit instance
    wide_vec(64'h0, 64'hDEAD_BEEF_0123_4567, "R10 R4 zero");
    wide_vec(64'h1, 64'hFEDC_BA98_7654_3210, "R10 R5 one");
    wide_vec('1, '1, "R10 R6 max");
    chk("R6 max closed form", p64, {{63{1'b1}}, 1'b0, {63{1'b0}}, 1'b1});
    for (int i = 0; i < 400; i++)
      wide_vec({$urandom, $urandom}, {$urandom, $urandom}, "R10 random");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule